// File: doc/BRIEF.md
# SMBus Host Register Bank

This block is the register face of an SMBus host controller. A small I/O port reaches it through a 4-bit offset, an 8-bit write bus, a read strobe, a write strobe and an access-enable input. It holds six byte registers: status, control, command, slave address and two data bytes. It also holds a 32-byte block buffer. A single data port reaches that buffer, and an index that advances after every access picks the entry.

The block does not drive the SMBus wires. It models only how the registers behave when software touches them, and that includes the side effects of accesses. Reading control rewinds the block index. Writing status clears status and rewinds the index. A write to any of the other scalar registers clears that register instead of storing the written byte. Block-data reads and writes both step the index, which wraps at the end of the buffer. While access is disabled, reads return all ones and writes have no effect.

The read data is combinational from the current offset. Side effects happen at the clock edge on which a qualified strobe is seen.

Top module: `smbus_hostregs`

## Requirements
- R1: The offset decodes as follows: 0x0 status, 0x2 control, 0x3 command, 0x4 slave address, 0x5 data byte 0, 0x6 data byte 1, 0x7 block data port.
- R2: A read at the control offset returns control bits [4:0], with bits [7:5] reading 0. A qualified read strobe at that offset sets the block index to 0.
- R3: A qualified write of any value to the status offset clears status and sets the block index to 0.
- R4: A qualified write to control, command, slave address, data byte 0 or data byte 1 leaves that register at zero, whatever byte is written.
- R5: A qualified access to the block data port reads or writes the buffer entry at the current index. The index then advances by one and wraps from 31 to 0.
- R6: A read at an unmapped offset (0x1 or 0x8 to 0xF) returns 0x00.
- R7: While acc_en is low, rdata is 0xFF. Strobes then change neither the buffer nor the block index.
- R8: After reset, every register, the block index and all 32 buffer entries are zero.
- R9: A change of offset with no strobe asserted leaves the block index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_en | input | 1 | Register access enable |
| rd_stb | input | 1 | Read strobe; the side effects of a read take effect at the clock edge |
| wr_stb | input | 1 | Write strobe |
| offset | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |

## Verification
The assertions assume that rd_stb and wr_stb are never high in the same cycle. They also assume that offset and the strobes are stable around each rising edge. The bench's tasks drive every input on the falling edge and raise only one strobe per access, which keeps both assumptions true. Index checks are made at the ports: a control read rewinds the index, and the bytes read back from the block port then show where the index stood.

// File: rtl/smbhr_pkg.sv
package smbhr_pkg;
  localparam int unsigned OFF_W = 4;

  typedef enum logic [OFF_W-1:0] {
    OFF_STAT = 4'h0,
    OFF_CTRL = 4'h2,
    OFF_CMD  = 4'h3,
    OFF_ADDR = 4'h4,
    OFF_DAT0 = 4'h5,
    OFF_DAT1 = 4'h6,
    OFF_BLK  = 4'h7
  } smbhr_off_e;

  localparam int unsigned CTRL_VIS_W = 5;
endpackage

// File: rtl/smbhr_index.sv
module smbhr_index #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr | step;
    if (clr)              idx_d = '0;
    else if (idx == LAST) idx_d = '0;
    else                  idx_d = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end
endmodule

// File: rtl/smbhr_buffer.sv
module smbhr_buffer #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[idx];
endmodule

// File: rtl/smbhr_regs.sv
module smbhr_regs
  import smbhr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [OFF_W-1:0]  offset,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] dat0_q,
  output logic [DATA_W-1:0] dat1_q
);
  localparam int unsigned NREG = 6;
  localparam logic [OFF_W-1:0] REG_OFF [NREG] =
    '{OFF_STAT, OFF_CTRL, OFF_CMD, OFF_ADDR, OFF_DAT0, OFF_DAT1};

  logic [DATA_W-1:0] reg_q [NREG];
  logic [DATA_W-1:0] reg_d [NREG];
  logic [NREG-1:0]   reg_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      reg_en[g] = wr_hit && (offset == REG_OFF[g]);
      reg_d[g]  = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q[g] <= '0;
      else if (reg_en[g]) reg_q[g] <= reg_d[g];
    end
  end

  assign stat_q = reg_q[0];
  assign ctrl_q = reg_q[1];
  assign cmd_q  = reg_q[2];
  assign addr_q = reg_q[3];
  assign dat0_q = reg_q[4];
  assign dat1_q = reg_q[5];
endmodule

// File: rtl/smbus_hostregs.sv
module smbus_hostregs
  import smbhr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned IDX_W = $clog2(BUF_DEPTH);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic rd_hit, wr_hit, blk_hit, idx_clr;
  logic [IDX_W-1:0]  blk_idx;
  logic [DATA_W-1:0] blk_rd;
  logic [DATA_W-1:0] stat_q, ctrl_q, cmd_q, addr_q, dat0_q, dat1_q;

  always_comb begin
    rd_hit  = acc_en && rd_stb;
    wr_hit  = acc_en && wr_stb;
    blk_hit = (rd_hit || wr_hit) && (offset == OFF_BLK);
    idx_clr = (rd_hit && (offset == OFF_CTRL)) ||
              (wr_hit && (offset == OFF_STAT));
  end

  smbhr_index #(.DEPTH(BUF_DEPTH)) u_index (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (idx_clr),
    .step (blk_hit),
    .idx  (blk_idx)
  );

  smbhr_buffer #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_buffer (
    .clk  (clk),
    .rst_n(rst_int_n),
    .we   (wr_hit && (offset == OFF_BLK)),
    .idx  (blk_idx),
    .wdata(wdata),
    .rdata(blk_rd)
  );

  smbhr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_hit(wr_hit),
    .offset(offset),
    .stat_q(stat_q),
    .ctrl_q(ctrl_q),
    .cmd_q (cmd_q),
    .addr_q(addr_q),
    .dat0_q(dat0_q),
    .dat1_q(dat1_q)
  );

  always_comb begin
    if (!acc_en) begin
      rdata = '1;
    end else begin
      unique case (offset)
        OFF_STAT: rdata = stat_q;
        OFF_CTRL: rdata = {{(DATA_W-CTRL_VIS_W){1'b0}}, ctrl_q[CTRL_VIS_W-1:0]};
        OFF_CMD:  rdata = cmd_q;
        OFF_ADDR: rdata = addr_q;
        OFF_DAT0: rdata = dat0_q;
        OFF_DAT1: rdata = dat1_q;
        OFF_BLK:  rdata = blk_rd;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/smbus_hostregs_chk.sv
module smbus_hostregs_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DEPTH  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [3:0]        offset,
  input logic [DATA_W-1:0] rdata,
  input logic [IDX_W-1:0]  idx
);
  // R7: disabled reads return all ones
  a_r7_disabled_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> rdata == '1);

  // R7: disabled strobes leave the index alone
  a_r7_disabled_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(idx));

  // R2: control read rewinds the index and shows only the low 5 bits
  a_r2_ctrl_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && rd_stb && offset == 4'h2) |=> idx == '0);
  a_r2_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && offset == 4'h2) |-> rdata[DATA_W-1:5] == '0);

  // R3: status write rewinds the index
  a_r3_stat_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && wr_stb && offset == 4'h0) |=> idx == '0);

  // R5: a block access steps the index, wrapping at the end
  a_r5_blk_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && (rd_stb || wr_stb) && offset == 4'h7) |=>
      idx == (($past(idx) == IDX_W'(DEPTH-1)) ? '0 : $past(idx) + 1'b1));

  // R6: unmapped offsets read zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && (offset == 4'h1 || offset > 4'h7)) |-> rdata == '0);

  // R9: no strobe, no index movement
  a_r9_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> $stable(idx));
endmodule

bind smbus_hostregs smbus_hostregs_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .DEPTH(BUF_DEPTH)
) u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .acc_en(acc_en),
  .rd_stb(rd_stb),
  .wr_stb(wr_stb),
  .offset(offset),
  .rdata (rdata),
  .idx   (blk_idx)
);

// File: tb/test_smbus_hostregs.sv
module test_smbus_hostregs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [3:0] offset = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smbus_hostregs i_smbus_hostregs (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .offset(offset), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk);
    offset = off; rd_stb = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd_stb = 1'b0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    offset = off; wdata = d; wr_stb = 1'b1;
    @(posedge clk); #1 wr_stb = 1'b0;
  endtask

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 7 + s) ^ 8'h5A);
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(4'h0, d); check("R8 status", d, 8'h00);
    rd(4'h2, d); check("R8 control", d, 8'h00);
    rd(4'h3, d); check("R8 command", d, 8'h00);
    rd(4'h4, d); check("R8 address", d, 8'h00);
    rd(4'h5, d); check("R8 data0", d, 8'h00);
    rd(4'h6, d); check("R8 data1", d, 8'h00);
    for (int i = 0; i < 32; i++) begin
      rd(4'h7, d); check("R8 buffer", d, 8'h00);
    end
  endtask

  task automatic t_block_roundtrip();
    logic [7:0] d;
    rd(4'h2, d);
    for (int i = 0; i < 32; i++) wr(4'h7, pat(i, 1));
    // R5: after 32 writes index wrapped to 0
    for (int i = 0; i < 32; i++) begin
      rd(4'h7, d); check("R5 roundtrip", d, pat(i, 1));
    end
    // R5 wrap: 33rd write lands in entry 0
    rd(4'h2, d);
    for (int i = 0; i < 33; i++) wr(4'h7, pat(i, 3));
    rd(4'h2, d);
    rd(4'h7, d); check("R5 wrap entry0", d, pat(32, 3));
    rd(4'h7, d); check("R5 wrap entry1", d, pat(1, 3));
  endtask

  task automatic t_ctrl_rewind();
    logic [7:0] d;
    rd(4'h2, d);
    rd(4'h7, d); rd(4'h7, d); rd(4'h7, d);
    rd(4'h2, d); check("R2 control mask", d, 8'h00);
    rd(4'h7, d); check("R2 rewind", d, pat(32, 3));
  endtask

  task automatic t_stat_clear();
    logic [7:0] d;
    rd(4'h7, d); rd(4'h7, d);
    wr(4'h0, 8'hFF);
    rd(4'h0, d); check("R3 status cleared", d, 8'h00);
    rd(4'h7, d); check("R3 rewind", d, pat(32, 3));
  endtask

  task automatic t_write_clears();
    logic [7:0] d;
    for (int o = 2; o <= 6; o++) begin
      wr(4'(o), 8'hA5);
      rd(4'(o), d); check("R4 write clears", d, 8'h00);
    end
    rd(4'h2, d); check("R1 control after writes", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(4'h1, d); check("R6 offset 1", d, 8'h00);
    rd(4'h8, d); check("R6 offset 8", d, 8'h00);
    rd(4'hF, d); check("R6 offset F", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    rd(4'h2, d);
    acc_en = 1'b0;
    rd(4'h7, d); check("R7 read ones", d, 8'hFF);
    rd(4'h1, d); check("R7 unmapped ones", d, 8'hFF);
    wr(4'h7, 8'h3C); wr(4'h7, 8'h3C);
    @(negedge clk); acc_en = 1'b1;
    rd(4'h7, d); check("R7 buffer untouched", d, pat(32, 3));
    rd(4'h7, d); check("R7 index untouched", d, pat(1, 3));
  endtask

  task automatic t_idle();
    logic [7:0] d;
    rd(4'h2, d);
    rd(4'h7, d);
    for (int o = 0; o < 16; o++) begin
      @(negedge clk); offset = 4'(o);
    end
    @(negedge clk); offset = 4'h2;
    @(negedge clk); offset = 4'h7;
    rd(4'h7, d); check("R9 idle index", d, pat(1, 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc_en = 1'b1;
    t_reset();
    t_block_roundtrip();
    t_ctrl_rewind();
    t_stat_clear();
    t_write_clears();
    t_unmapped();
    t_disabled();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule